// File: doc/BRIEF.md
# Pin-Level Data Register with Protected Half-Word Writes

This block holds the data value of one general-purpose I/O bank of WIDTH pins (26 or 32) behind a 32-bit register bus. Software can replace the whole value with one write. It can also change selected pins in the lower or upper half through a write that carries a protect mask, so no read-modify-write sequence is needed. A pin is driven from its data bit only when it is set as an output and its driver is enabled. Pins set as inputs copy their level into the same register whenever that level changes.

A read-only alias returns the stored value. A synchronous warm reset returns the direction and driver-enable registers to zero and leaves the data value untouched. The asynchronous power-on reset clears everything. Bus reads are combinational in the cycle where `bus_sel` is high and `bus_wr` is low. Writes take effect at the next rising clock edge.

Top module: `gpiob_data_bank`

## Requirements
- R1: A write to offset 0x04 updates data bits 15:0. For each bit i, wdata[16+i]=1 keeps the stored bit and wdata[16+i]=0 loads wdata[i]. Data bits 16 and above are unchanged.
- R2: A write to offset 0x08 updates data bits 16 to WIDTH-1. For each j, wdata[16+j]=1 keeps data bit 16+j and wdata[16+j]=0 loads wdata[j]. On a 26-pin bank, wdata bits 31:26 and 15:10 have no effect. Bits 15:0 are unchanged.
- R3: A write to offset 0x00 stores wdata[WIDTH-1:0]. A read of 0x00 returns the stored value, with bits WIDTH and above read as zero.
- R4: Reads of offsets 0x04 and 0x08 always return zero.
- R5: pin_out[i] equals data bit i when direction bit i (offset 0x10, 1 = output) and enable bit i (offset 0x14) are both 1. Otherwise pin_out[i] is 0.
- R6: For a pin whose direction bit is 0, a change of pin_in[i] is stored into data bit i at the next clock edge. For a pin whose direction bit is 1, pin_in[i] has no effect on the data bit.
- R7: A read of offset 0x0C returns the data value. Writes to 0x0C change nothing.
- R8: A cycle with warm_rst high clears the direction and enable registers at the next edge and keeps the data value.
- R9: While por_n is low, data, direction and enable are all zero, so pin_out and pin_oe are zero.
- R10: pin_oe presents the enable register and changes at the clock edge that performs a write to 0x14.
- R11: An access whose address bits 1:0 are not zero writes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pin_in | input | WIDTH | Sampled pin levels |
| pin_out | output | WIDTH | Pin output levels |
| pin_oe | output | WIDTH | Per-pin driver enable |

## Verification
The hardest state to reach is a data value that mixes bits written by software with bits captured from pins. This has to hold while the direction register splits the bank between inputs and outputs. The stimulus first sets four pins as outputs. It then toggles pin levels on both sides of that boundary and checks that only the input-side bits follow. After that it writes a patterned value and pulses warm reset, to show that the mixed value survives while direction and enable drop to zero. The protected half-word writes are walked through vectors that use all-keep, partial and all-load masks, plus set reserved bits on the narrow upper half.

// File: rtl/gpiob_pkg.sv
package gpiob_pkg;

    localparam int unsigned OFF_DATA   = 32'h00;
    localparam int unsigned OFF_MLO    = 32'h04;
    localparam int unsigned OFF_MHI    = 32'h08;
    localparam int unsigned OFF_MIRROR = 32'h0C;
    localparam int unsigned OFF_DIR    = 32'h10;
    localparam int unsigned OFF_OEN    = 32'h14;
    localparam int unsigned HALF_W     = 16;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_DATA,
        REG_MLO,
        REG_MHI,
        REG_MIRROR,
        REG_DIR,
        REG_OEN
    } reg_sel_e;

    typedef struct packed {
        logic wr_data;
        logic wr_mlo;
        logic wr_mhi;
        logic wr_dir;
        logic wr_oen;
    } wr_strobe_t;

endpackage

// File: rtl/gpiob_decode.sv
module gpiob_decode
    import gpiob_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          reg_sel,
    output wr_strobe_t        wr_stb
);

    logic aligned;
    assign aligned = (bus_addr[1:0] == 2'b00);

    always_comb begin
        reg_sel = REG_NONE;
        if (bus_sel && aligned) begin
            case (bus_addr)
                ADDR_W'(OFF_DATA):   reg_sel = REG_DATA;
                ADDR_W'(OFF_MLO):    reg_sel = REG_MLO;
                ADDR_W'(OFF_MHI):    reg_sel = REG_MHI;
                ADDR_W'(OFF_MIRROR): reg_sel = REG_MIRROR;
                ADDR_W'(OFF_DIR):    reg_sel = REG_DIR;
                ADDR_W'(OFF_OEN):    reg_sel = REG_OEN;
                default:             reg_sel = REG_NONE;
            endcase
        end
    end

    always_comb begin
        wr_stb = '0;
        if (bus_wr) begin
            case (reg_sel)
                REG_DATA: wr_stb.wr_data = 1'b1;
                REG_MLO:  wr_stb.wr_mlo  = 1'b1;
                REG_MHI:  wr_stb.wr_mhi  = 1'b1;
                REG_DIR:  wr_stb.wr_dir  = 1'b1;
                REG_OEN:  wr_stb.wr_oen  = 1'b1;
                default:  wr_stb = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpiob_merge.sv
module gpiob_merge
    import gpiob_pkg::*;
#(
    parameter int WIDTH = 26
) (
    input  logic [WIDTH-1:0] old_val,
    input  logic [31:0]      wdata,
    output logic [WIDTH-1:0] lo_val,
    output logic [WIDTH-1:0] hi_val
);

    localparam int HI_W = WIDTH - HALF_W;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i < HALF_W) begin : g_low
            // keep when the protect bit is set, else load the new bit
            assign lo_val[i] = wdata[HALF_W + i] ? old_val[i] : wdata[i];
            assign hi_val[i] = old_val[i];
        end else begin : g_high
            assign lo_val[i] = old_val[i];
            assign hi_val[i] = wdata[i] ? old_val[i] : wdata[i - HALF_W];
        end
    end

    if (HI_W < 1) begin : g_bad_width
        initial $display("gpiob_merge: WIDTH must exceed 16");
    end

endmodule

// File: rtl/gpiob_pins.sv
module gpiob_pins #(
    parameter int WIDTH = 26
) (
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] oen_q,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] prev_q,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] cap_mask
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign pin_out[i]  = data_q[i] & dir_q[i] & oen_q[i];
        assign cap_mask[i] = (pin_in[i] ^ prev_q[i]) & ~dir_q[i];
    end

endmodule

// File: rtl/gpiob_data_bank.sv
module gpiob_data_bank
    import gpiob_pkg::*;
#(
    parameter int WIDTH  = 26,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] oen;
        logic [WIDTH-1:0] prev;
    } bank_state_t;

    bank_state_t st_d, st_q;

    reg_sel_e         reg_sel;
    wr_strobe_t       wr_stb;
    logic [WIDTH-1:0] lo_val;
    logic [WIDTH-1:0] hi_val;
    logic [WIDTH-1:0] cap_mask;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] prev_q;

    assign data_q = st_q.data;
    assign prev_q = st_q.prev;

    gpiob_decode #(.ADDR_W(ADDR_W)) i_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .reg_sel  (reg_sel),
        .wr_stb   (wr_stb)
    );

    gpiob_merge #(.WIDTH(WIDTH)) i_merge (
        .old_val (st_q.data),
        .wdata   (bus_wdata),
        .lo_val  (lo_val),
        .hi_val  (hi_val)
    );

    gpiob_pins #(.WIDTH(WIDTH)) i_pins (
        .data_q   (st_q.data),
        .dir_q    (st_q.dir),
        .oen_q    (st_q.oen),
        .pin_in   (pin_in),
        .prev_q   (st_q.prev),
        .pin_out  (pin_out),
        .cap_mask (cap_mask)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_in;
        if (warm_rst) begin
            st_d.dir = '0;
            st_d.oen = '0;
        end else begin
            if (wr_stb.wr_data) st_d.data = bus_wdata[WIDTH-1:0];
            if (wr_stb.wr_mlo)  st_d.data = lo_val;
            if (wr_stb.wr_mhi)  st_d.data = hi_val;
            if (wr_stb.wr_dir)  st_d.dir  = bus_wdata[WIDTH-1:0];
            if (wr_stb.wr_oen)  st_d.oen  = bus_wdata[WIDTH-1:0];
            // a pin level change wins over a bus write on input pins
            st_d.data = (st_d.data & ~cap_mask) | (pin_in & cap_mask);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_wr) begin
            case (reg_sel)
                REG_DATA, REG_MIRROR: bus_rdata = 32'(st_q.data);
                REG_DIR:              bus_rdata = 32'(st_q.dir);
                REG_OEN:              bus_rdata = 32'(st_q.oen);
                default:              bus_rdata = '0;
            endcase
        end
    end

    assign pin_oe = st_q.oen;

endmodule

// File: rtl/gpiob_checker.sv
module gpiob_checker #(
    parameter int WIDTH  = 26,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              por_n,
    input logic              warm_rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [WIDTH-1:0]  pin_in,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  data_q,
    input logic [WIDTH-1:0]  prev_q
);

    AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!por_n)
        (pin_out & ~pin_oe) == '0); // R5

    AST_MASKED_READ_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && !bus_wr && (bus_addr == ADDR_W'(4) || bus_addr == ADDR_W'(8)))
        |-> bus_rdata == 32'd0); // R4

    AST_MIRROR_EQ_DATA: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(12)) |-> bus_rdata == 32'(data_q)); // R7

    AST_MIRROR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(12) && pin_in == prev_q)
        |=> $stable(data_q)); // R7

    AST_WARM_KEEPS_DATA: assert property (@(posedge clk) disable iff (!por_n)
        warm_rst |=> $stable(data_q)); // R8

    AST_WARM_CLEARS_OE: assert property (@(posedge clk) disable iff (!por_n)
        warm_rst |=> pin_oe == '0); // R8

    AST_UNALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && !bus_wr && bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'd0); // R11

    AST_LOW_KEEP_ALL: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(4) && bus_wdata[31:16] == 16'hFFFF
         && pin_in == prev_q && !warm_rst) |=> $stable(data_q)); // R1

endmodule

bind gpiob_data_bank gpiob_checker #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_gpiob_checker (
    .clk       (clk),
    .por_n     (por_n),
    .warm_rst  (warm_rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .data_q    (data_q),
    .prev_q    (prev_q)
);

// File: tb/test_gpiob_data_bank.sv
`timescale 1ns/1ps
module test_gpiob_data_bank;

    localparam int WIDTH  = 26;
    localparam int ADDR_W = 8;
    localparam int NVEC   = 9;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              warm_rst = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [WIDTH-1:0]  pin_in = '0;
    logic [WIDTH-1:0]  pin_out;
    logic [WIDTH-1:0]  pin_oe;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    gpiob_data_bank #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_gpiob_data_bank (
        .clk(clk), .por_n(por_n), .warm_rst(warm_rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {requirement number, address, write data, expected value at 0x00}
    localparam logic [75:0] VECS [NVEC] = '{
        {4'd3, 8'h00, 32'hFFFF_FFFF, 32'h03FF_FFFF},  // R3 upper bits dropped
        {4'd1, 8'h04, 32'hFFFF_0000, 32'h03FF_FFFF},  // R1 keep every bit
        {4'd1, 8'h04, 32'h00FF_1234, 32'h03FF_12FF},  // R1 partial keep
        {4'd2, 8'h08, 32'h0000_0155, 32'h0155_12FF},  // R2 load all ten
        {4'd2, 8'h08, 32'hFC00_FFFF, 32'h03FF_12FF},  // R2 reserved bits ignored
        {4'd2, 8'h08, 32'h03FE_0000, 32'h03FE_12FF},  // R2 load only bit 16
        {4'd7, 8'h0C, 32'h0000_0000, 32'h03FE_12FF},  // R7 alias write ignored
        {4'd3, 8'h00, 32'h0000_0000, 32'h0000_0000},  // R3 clear
        {4'd11, 8'h01, 32'hFFFF_FFFF, 32'h0000_0000}  // R11 misaligned write
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 pin_out in reset", 32'(pin_out), 32'd0);
        por_n = 1'b1;
        rdreg(8'h00, rd); check("R9 data", rd, 32'd0);
        rdreg(8'h10, rd); check("R9 dir", rd, 32'd0);
        rdreg(8'h14, rd); check("R9 enable", rd, 32'd0);
        check("R9 pin_oe", 32'(pin_oe), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i][71:64], VECS[i][63:32]);
            rdreg(8'h00, rd);
            check($sformatf("R%0d vector %0d", VECS[i][75:72], i), rd, VECS[i][31:0]);
        end

        // R4 protected-write offsets read zero
        wr(8'h04, 32'h0000_1111);
        rdreg(8'h04, rd); check("R4 low", rd, 32'd0);
        rdreg(8'h08, rd); check("R4 high", rd, 32'd0);
        rdreg(8'h00, rd); check("R1 load all low", rd, 32'h0000_1111);

        // R10 enable appears at the write edge
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h03FF_FFFF;
        #1 check("R10 before edge", 32'(pin_oe), 32'd0);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R10 after edge", 32'(pin_oe), 32'h03FF_FFFF);
        rdreg(8'h14, rd); check("R10 readback", rd, 32'h03FF_FFFF);

        // R5 output gating
        wr(8'h10, 32'h0000_000F);
        wr(8'h00, 32'h0000_0005);
        check("R5 dir and enable", 32'(pin_out), 32'h5);
        wr(8'h14, 32'h0000_0003);
        check("R5 enable subset", 32'(pin_out), 32'h1);

        // R6 capture on input pins only
        @(negedge clk); pin_in = 26'h30;
        rdreg(8'h00, rd); check("R6 inputs captured", rd, 32'h35);
        @(negedge clk); pin_in = 26'h32;
        rdreg(8'h00, rd); check("R6 output pin ignored", rd, 32'h35);
        @(negedge clk); pin_in = 26'h00;
        rdreg(8'h00, rd); check("R6 inputs fall", rd, 32'h05);

        // R8 warm reset keeps data
        wr(8'h00, 32'h02AA_AAAA);
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); warm_rst = 1'b0;
        rdreg(8'h00, rd); check("R8 data kept", rd, 32'h02AA_AAAA);
        rdreg(8'h10, rd); check("R8 dir cleared", rd, 32'd0);
        rdreg(8'h14, rd); check("R8 enable cleared", rd, 32'd0);
        check("R8 pin_oe", 32'(pin_oe), 32'd0);

        // R11 misaligned access
        rdreg(8'h0D, rd); check("R11 read zero", rd, 32'd0);
        wr(8'h11, 32'h0000_00FF);
        rdreg(8'h10, rd); check("R11 dir untouched", rd, 32'd0);

        // R7 alias read
        rdreg(8'h0C, rd); check("R7 alias", rd, 32'h02AA_AAAA);

        // R9 power-on reset clears data
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rdreg(8'h00, rd); check("R9 data after second reset", rd, 32'd0);

        summary();
    end

endmodule